// File: doc/BRIEF.md
# Delay-Line Time Stamp Encoder

This block turns one sample of a tapped delay line into a time stamp. Each clock edge latches the taps. The latched word is a thermometer code: ones at the bottom, zeros above. The number of ones measures the time from the input hit to the clock edge that captured it. A free-running cycle counter supplies the coarse time.

When the taps go from all-zero to non-zero, the block records a hit. It counts the ones in the word, so single bubbles do not shift the result. It then passes that raw count through a correction table loaded by software. Finally it subtracts the corrected fine value from the scaled coarse count. This gives a stamp that points back from the capture edge to the hit, and the stamp comes out with a one-cycle valid strobe.

The default build has 352 taps, which at roughly 23 ps per tap spans an 8 ns (125 MHz) period. It also has a 34-bit coarse counter, which covers more than 42 s. Software fills the table through its own write port, which is separate from the measurement path.

Top module: `tdc_stamp_encoder`

## Requirements
- R1: After reset, `stamp_valid_o` is 0 and `stamp_o` is 0.
- R2: A hit is recorded only when the tap word sampled at an edge is non-zero and the word sampled at the previous edge was all-zero. A word that stays non-zero over several edges gives exactly one stamp.
- R3: The stamp for taps sampled at edge k appears after edge k+3, and `stamp_valid_o` is high for exactly one cycle.
- R4: The raw fine code is the number of ones in the tap word (0 to TAPS), whatever their positions. A zero inside the run of ones, or a one above it, does not change the count.
- R5: The corrected fine value is the table entry whose address equals the raw fine code.
- R6: `stamp_o` equals (coarse × 2^FINE_W − corrected) modulo 2^(COARSE_W+FINE_W), where FINE_W = clog2(TAPS+1).
- R7: The coarse counter is 0 at the first edge after reset, rises by one every cycle, and wraps modulo 2^COARSE_W. The coarse value in a stamp is the counter value at the hit edge. The default width gives at least 42 s at 8 ns per count.
- R8: A table write with `tbl_we` high stores `tbl_data` at `tbl_addr` on the rising edge. A write does not disturb a stamp in flight that reads another address, and later hits with that code use the new value.
- R9: An all-zero tap word never produces a stamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| taps_i | input | TAPS | Latched delay-line taps (thermometer code) |
| tbl_we | input | 1 | Correction table write enable |
| tbl_addr | input | FINE_W | Correction table write address (raw fine code) |
| tbl_data | input | FINE_W | Corrected fine value to store |
| stamp_valid_o | output | 1 | One-cycle strobe for a new stamp |
| stamp_o | output | COARSE_W+FINE_W | Time stamp: coarse × 2^FINE_W − corrected fine |

## Verification
The bench sweeps every thermometer length from one tap to the full line, then repeats the sweep with bubbles injected. A design that located the first zero instead of counting ones would shorten the code at each bubble. A word held non-zero for several cycles must give a single stamp; level-based detection would stream stamps. Runs long enough to wrap the coarse counter expose a wrong borrow in the stamp subtraction. A table write placed mid-flight catches a read port that picks up the wrong address.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  localparam int DEF_TAPS     = 352;
  localparam int DEF_COARSE_W = 34;

  function automatic int fine_width(input int taps);
    return $clog2(taps + 1);
  endfunction
endpackage

// File: rtl/tdc_hit_detect.sv
module tdc_hit_detect #(
  parameter int TAPS     = 352,
  parameter int COARSE_W = 34
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [TAPS-1:0]     taps_i,
  input  logic [COARSE_W-1:0] coarse_i,
  output logic                hit_o,
  output logic [TAPS-1:0]     taps_o,
  output logic [COARSE_W-1:0] coarse_o
);
  logic busy_q;
  logic any_now;

  assign any_now = |taps_i;

  always_ff @(posedge clk) begin
    busy_q   <= any_now;
    taps_o   <= taps_i;
    coarse_o <= coarse_i;
    if (rst) hit_o <= 1'b0;
    else     hit_o <= any_now && !busy_q;
  end

  a_r2_no_rehit: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(|taps_i, 2) && $past(|taps_i)) |-> !hit_o);

  a_r9_hit_needs_taps: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && hit_o) |-> $past(|taps_i));
endmodule

// File: rtl/tdc_ones_count.sv
module tdc_ones_count #(
  parameter int TAPS   = 352,
  parameter int FINE_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TAPS-1:0]   taps_i,
  output logic [FINE_W-1:0] count_o
);
  localparam int GROUP  = 16;
  localparam int NGROUP = (TAPS + GROUP - 1) / GROUP;

  logic [NGROUP-1:0][FINE_W-1:0] part;

  for (genvar g = 0; g < NGROUP; g++) begin : g_grp
    always_comb begin
      part[g] = '0;
      for (int b = 0; b < GROUP; b++) begin
        if (g * GROUP + b < TAPS)
          part[g] = part[g] + FINE_W'(taps_i[g * GROUP + b]);
      end
    end
  end

  logic [FINE_W-1:0] total;
  always_comb begin
    total = '0;
    for (int g = 0; g < NGROUP; g++) total = total + part[g];
  end

  always_ff @(posedge clk) begin
    if (rst) count_o <= '0;
    else     count_o <= total;
  end

  a_r4_full_line: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(&taps_i)) |-> (count_o == FINE_W'(TAPS)));

  a_r4_empty_line: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(taps_i == '0)) |-> (count_o == '0));
endmodule

// File: rtl/tdc_corr_ram.sv
module tdc_corr_ram #(
  parameter int FINE_W = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic [FINE_W-1:0] waddr,
  input  logic [FINE_W-1:0] wdata,
  input  logic [FINE_W-1:0] raddr,
  output logic [FINE_W-1:0] rdata
);
  localparam int DEPTH = 1 << FINE_W;

  logic [FINE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tdc_stamp_encoder.sv
module tdc_stamp_encoder
  import tdc_pkg::*;
#(
  parameter int TAPS     = DEF_TAPS,
  parameter int COARSE_W = DEF_COARSE_W,
  parameter int FINE_W   = fine_width(TAPS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [TAPS-1:0]            taps_i,
  input  logic                       tbl_we,
  input  logic [FINE_W-1:0]          tbl_addr,
  input  logic [FINE_W-1:0]          tbl_data,
  output logic                       stamp_valid_o,
  output logic [COARSE_W+FINE_W-1:0] stamp_o
);
  localparam int STAMP_W = COARSE_W + FINE_W;

  logic [COARSE_W-1:0] coarse_cnt;
  always_ff @(posedge clk) begin
    if (rst) coarse_cnt <= '0;
    else     coarse_cnt <= coarse_cnt + 1'b1;
  end

  logic                hit_s1;
  logic [TAPS-1:0]     taps_s1;
  logic [COARSE_W-1:0] coarse_s1;

  tdc_hit_detect #(.TAPS(TAPS), .COARSE_W(COARSE_W)) u_hit (
    .clk(clk), .rst(rst), .taps_i(taps_i), .coarse_i(coarse_cnt),
    .hit_o(hit_s1), .taps_o(taps_s1), .coarse_o(coarse_s1)
  );

  logic [FINE_W-1:0] raw_s2;
  tdc_ones_count #(.TAPS(TAPS), .FINE_W(FINE_W)) u_cnt (
    .clk(clk), .rst(rst), .taps_i(taps_s1), .count_o(raw_s2)
  );

  logic                hit_s2, hit_s3;
  logic [COARSE_W-1:0] coarse_s2, coarse_s3;
  always_ff @(posedge clk) begin
    coarse_s2 <= coarse_s1;
    coarse_s3 <= coarse_s2;
    if (rst) begin
      hit_s2 <= 1'b0;
      hit_s3 <= 1'b0;
    end else begin
      hit_s2 <= hit_s1;
      hit_s3 <= hit_s2;
    end
  end

  logic [FINE_W-1:0] corr_s3;
  tdc_corr_ram #(.FINE_W(FINE_W)) u_ram (
    .clk(clk), .we(tbl_we), .waddr(tbl_addr), .wdata(tbl_data),
    .raddr(raw_s2), .rdata(corr_s3)
  );

  logic [STAMP_W-1:0] edge_time;
  assign edge_time = {coarse_s3, {FINE_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      stamp_valid_o <= 1'b0;
      stamp_o       <= '0;
    end else begin
      stamp_valid_o <= hit_s3;
      if (hit_s3) stamp_o <= edge_time - STAMP_W'(corr_s3);
    end
  end

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    stamp_valid_o |=> !stamp_valid_o);

  a_r7_coarse_step: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (coarse_cnt == $past(coarse_cnt) + 1'b1));

  a_r9_stamp_from_edge: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst, 1) && !$past(rst, 2) && !$past(rst, 3) && !$past(rst, 4)
     && stamp_valid_o) |-> $past(|taps_i, 4));
endmodule

// File: tb/test_tdc_stamp_encoder.sv
`timescale 1ns/1ps
module test_tdc_stamp_encoder;
  localparam int TAPS = 24;
  localparam int CW   = 8;
  localparam int FW   = 5;
  localparam int SW   = CW + FW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [TAPS-1:0] taps = '0;
  logic          we = 1'b0;
  logic [FW-1:0] wa = '0;
  logic [FW-1:0] wd = '0;
  logic          vld;
  logic [SW-1:0] stamp;

  int checks = 0;
  int errors = 0;
  int pc = 0;
  int corr_m [32];

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (rst) pc <= 0;
    else     pc <= pc + 1;
  end

  tdc_stamp_encoder #(.TAPS(TAPS), .COARSE_W(CW)) i_tdc_stamp_encoder (
    .clk(clk), .rst(rst), .taps_i(taps), .tbl_we(we), .tbl_addr(wa),
    .tbl_data(wd), .stamp_valid_o(vld), .stamp_o(stamp)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tbl_write(input int a, input int d);
    @(negedge clk);
    we = 1'b1; wa = FW'(a); wd = FW'(d);
    corr_m[a] = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  // One isolated hit; optional table write while it is in flight.
  task automatic do_hit(input logic [TAPS-1:0] t, input int ones, input string req,
                        input bit mid_wr, input int ma, input int md);
    int ec;
    int exp;
    @(negedge clk);
    taps = t;
    ec = pc % (1 << CW);
    @(negedge clk);
    taps = '0;
    check({req, " R3 no early valid"}, vld, 0);
    if (mid_wr) begin
      we = 1'b1; wa = FW'(ma); wd = FW'(md);
    end
    @(negedge clk);
    we = 1'b0;
    check({req, " R3 no early valid"}, vld, 0);
    @(negedge clk);
    check({req, " R3 no early valid"}, vld, 0);
    @(negedge clk);
    exp = ((ec << FW) - corr_m[ones] + (1 << SW)) % (1 << SW);
    check({req, " R3 valid at latency 3"}, vld, 1);
    check({req, " R6 stamp"}, stamp, exp);
    if (mid_wr) corr_m[ma] = md;
    @(negedge clk);
    check({req, " R3 one-cycle pulse"}, vld, 0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1 valid after reset", vld, 0);
    check("R1 stamp after reset", stamp, 0);
    rst = 1'b0;

    for (int a = 0; a < 32; a++) tbl_write(a, (7 * a + 3) % 32);

    // R4/R5: every thermometer length
    for (int k = 1; k <= TAPS; k++)
      do_hit(TAPS'((1 << k) - 1), k, "R4 R5 thermometer", 1'b0, 0, 0);

    // R4: bubbles below and above the edge keep the count
    for (int k = 4; k < TAPS - 1; k++) begin
      logic [TAPS-1:0] t;
      t = TAPS'((1 << k) - 1);
      t[k - 3] = 1'b0;
      t[k + 1] = 1'b1;
      do_hit(t, k, "R4 bubble", 1'b0, 0, 0);
    end

    // R2: sustained non-zero word gives one stamp
    begin
      int nv = 0;
      @(negedge clk);
      taps = TAPS'(32'hff);
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        nv += int'(vld);
      end
      taps = '0;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        nv += int'(vld);
      end
      check("R2 one stamp for held word", nv, 1);
    end

    // R9: zeros only
    begin
      int nv = 0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        nv += int'(vld);
      end
      check("R9 no stamp on zero taps", nv, 0);
    end

    // R8: write code 10 while a code-5 hit is in flight, then use code 10
    do_hit(TAPS'(5'h1f), 5, "R8 in-flight write", 1'b1, 10, 29);
    do_hit(TAPS'(10'h3ff), 10, "R8 new table value", 1'b0, 0, 0);

    // R7: run past a coarse wrap and keep stamping
    while (pc < 700) @(negedge clk);
    for (int k = 1; k <= 3; k++)
      do_hit(TAPS'((1 << k) - 1), k, "R7 after coarse wrap", 1'b0, 0, 0);
    check("R7 run crossed coarse wrap", int'(pc > (1 << CW)), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule